// File: doc/BRIEF.md
# Test-Bus Register Write Engine

This block turns a single write request (a port select, a register address and an 8-bit value) into the clocked write sequence that a PHY's parallel test-register interface expects. It packs the request into one control word that carries the value, the address, the port select, a write-enable bit and an active-low test reset that is held high. It then steps that word through three phases of equal length: clock bit low, clock bit high, clock bit low. The PHY captures the write on the single rising edge of the clock bit.

Two field layouts are supported and one is picked at build time by a parameter. The wide layout uses 24 bits, with an 8-bit address and a 3-bit port. The narrow layout uses 16 bits, with a 4-bit address and a 1-bit port. The requester sees a ready signal that is high only while the engine is idle, and a one-cycle acknowledge once the last low phase has finished. When no write is running, the bus keeps the last word with its clock bit low.

Top module: `tbus_wr_engine`

## Requirements
- R1: While reset is low and in the cycle after it, `tbus` is all zeros, `req_ready` is 1 and `ack` is 0. A reset in the middle of a write abandons that write.
- R2: In every phase of a write, bits 7:0 of `tbus` hold `req_data`, in both layouts.
- R3: With LAYOUT=0 the word holds the address in bits 15:8, the port in bits 18:16, write enable at bit 21, the clock at bit 22 and the active-low test reset at bit 23. Bits 20:19 are 0.
- R4: With LAYOUT=1 the word holds the address in bits 11:8, the port in bit 12, write enable at bit 13, the clock at bit 14 and the test reset at bit 15. Bits 23:16 are always 0.
- R5: Address and port bits above the width of their field are dropped and never reach a neighbouring field.
- R6: An accepted write drives the clock bit low for PHASE_CYCLES cycles, then high for PHASE_CYCLES cycles, then low for PHASE_CYCLES cycles, counted from the cycle after the accepting edge. This gives exactly one rising edge.
- R7: In all three phases the write-enable and test-reset bits are 1, and every bit except the clock bit keeps the same value.
- R8: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the write ends, and a request made while busy changes nothing.
- R9: `ack` is high for exactly one cycle, the cycle right after the final low phase. In that cycle `req_ready` is high again, so a new request can be accepted in the same cycle.
- R10: While idle with no new request, `tbus` holds the last written word with its clock bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_port | input | PORT_W | Target port select |
| req_addr | input | ADDR_W | Test register address |
| req_data | input | 8 | Value to write |
| ack | output | 1 | One-cycle pulse when a write has completed |
| tbus | output | 24 | Packed control word to the PHY test interface |

## Verification
The bench uses address and port values that overflow the narrow layout's fields. An engine that forgets to mask them would corrupt the write-enable or clock bits, and the bench would see a wrong word or a wrong edge. It checks every cycle of every phase with phases longer than one cycle, which catches a counter that is off by one: such an engine would stretch or shorten a phase, or pulse the clock twice. It raises a request in the middle of a write, and an engine that took it would reload the word before the high phase ended. It chains a new request into the acknowledge cycle and resets the engine during a write, which would expose a lost back-to-back request or a clock bit left high.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

  localparam int BUS_W  = 24;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO1  = 2'd1,
    PH_HI   = 2'd2,
    PH_LO2  = 2'd3
  } phase_t;

  // field geometry, per layout
  function automatic int addr_w(input int lay);
    return (lay == 0) ? 8 : 4;
  endfunction

  function automatic int port_w(input int lay);
    return (lay == 0) ? 3 : 1;
  endfunction

  function automatic int port_pos(input int lay);
    return (lay == 0) ? 16 : 12;
  endfunction

  function automatic int we_pos(input int lay);
    return (lay == 0) ? 21 : 13;
  endfunction

  function automatic int clk_pos(input int lay);
    return (lay == 0) ? 22 : 14;
  endfunction

  function automatic int rst_pos(input int lay);
    return (lay == 0) ? 23 : 15;
  endfunction

  function automatic logic [31:0] low_mask(input int w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // assemble a control word; fields are masked before shifting
  function automatic logic [BUS_W-1:0] pack_word(
    input int              lay,
    input logic [31:0]     port,
    input logic [31:0]     addr,
    input logic [DATA_W-1:0] data,
    input logic            ck
  );
    logic [31:0] t;
    t = 32'(data);
    t = t | ((addr & low_mask(addr_w(lay))) << DATA_W);
    t = t | ((port & low_mask(port_w(lay))) << port_pos(lay));
    t = t | (32'd1 << we_pos(lay));
    t = t | (32'd1 << rst_pos(lay));
    t = t | (32'(ck) << clk_pos(lay));
    return t[BUS_W-1:0];
  endfunction

endpackage

// File: rtl/tbus_word_pack.sv
module tbus_word_pack
  import tbus_pkg::*;
#(
  parameter int LAYOUT = 0,
  parameter int PORT_W = 3,
  parameter int ADDR_W = 8
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BUS_W-1:0]  word_lo_o,
  output logic [BUS_W-1:0]  clk_mask_o
);

  logic [31:0] port32;
  logic [31:0] addr32;

  assign port32 = 32'(port_i);
  assign addr32 = 32'(addr_i);

  generate
    if (LAYOUT == 0) begin : g_wide
      assign word_lo_o  = pack_word(0, port32, addr32, data_i, 1'b0);
      assign clk_mask_o = BUS_W'(32'd1 << clk_pos(0));
    end else begin : g_narrow
      assign word_lo_o  = pack_word(1, port32, addr32, data_i, 1'b0);
      assign clk_mask_o = BUS_W'(32'd1 << clk_pos(1));
    end
  endgenerate

endmodule

// File: rtl/tbus_phase_timer.sv
module tbus_phase_timer #(
  parameter int PHASE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic last_o
);

  localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !run_i || last_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tbus_wr_fsm.sv
module tbus_wr_fsm
  import tbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept_i,
  input  logic   last_i,
  output phase_t phase_o,
  output logic   ack_o
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept_i) phase_d = PH_LO1;
      PH_LO1:  if (last_i)   phase_d = PH_HI;
      PH_HI:   if (last_i)   phase_d = PH_LO2;
      PH_LO2:  if (last_i)   phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ack_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ack_o   <= (phase_q == PH_LO2) && last_i;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/tbus_wr_engine.sv
module tbus_wr_engine
  import tbus_pkg::*;
#(
  parameter int LAYOUT       = 0,
  parameter int PHASE_CYCLES = 2,
  parameter int PORT_W       = 3,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              ack,
  output logic [BUS_W-1:0]  tbus
);

  logic [BUS_W-1:0] word_lo;
  logic [BUS_W-1:0] clk_mask;
  logic [BUS_W-1:0] tbus_q;
  phase_t           phase;
  logic             accept;
  logic             phase_last;
  logic             to_hi;
  logic             to_lo;
  logic             finish;

  tbus_word_pack #(
    .LAYOUT (LAYOUT),
    .PORT_W (PORT_W),
    .ADDR_W (ADDR_W)
  ) u_pack (
    .port_i     (req_port),
    .addr_i     (req_addr),
    .data_i     (req_data),
    .word_lo_o  (word_lo),
    .clk_mask_o (clk_mask)
  );

  tbus_phase_timer #(
    .PHASE_CYCLES (PHASE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .run_i     (phase != PH_IDLE),
    .last_o    (phase_last)
  );

  tbus_wr_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .last_i   (phase_last),
    .phase_o  (phase),
    .ack_o    (ack)
  );

  // named events for checking
  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign to_hi     = (phase == PH_LO1) && phase_last;
  assign to_lo     = (phase == PH_HI)  && phase_last;
  assign finish    = (phase == PH_LO2) && phase_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbus_q <= '0;
    end else if (accept) begin
      tbus_q <= word_lo;
    end else if (to_hi) begin
      tbus_q <= tbus_q | clk_mask;
    end else if (to_lo) begin
      tbus_q <= tbus_q & ~clk_mask;
    end
  end

  assign tbus = tbus_q;

endmodule

// File: rtl/tbus_wr_engine_chk.sv
module tbus_wr_engine_chk
  import tbus_pkg::*;
#(
  parameter int LAYOUT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             ack,
  input logic [BUS_W-1:0] tbus,
  input logic             accept,
  input logic             to_hi,
  input logic             to_lo,
  input logic             finish
);

  localparam int CKB = clk_pos(LAYOUT);
  localparam int WEB = we_pos(LAYOUT);
  localparam int RSB = rst_pos(LAYOUT);
  localparam logic [BUS_W-1:0] CKM = BUS_W'(32'd1 << CKB);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r8_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);

  a_r6_rise_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
    to_hi |=> $rose(tbus[CKB]));

  a_r6_fall_on_lo: assert property (@(posedge clk) disable iff (!rst_n)
    to_lo |=> $fell(tbus[CKB]));

  a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tbus[CKB]);

  a_r7_we_rst_high: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (tbus[WEB] && tbus[RSB]));

  a_r7_fields_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ((tbus & ~CKM) == ($past(tbus) & ~CKM)));

  a_r9_ack_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (ack && req_ready));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_ready) && !$past(accept)) |-> $stable(tbus));

  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (LAYOUT == 0) || (tbus[BUS_W-1:16] == '0));

endmodule

bind tbus_wr_engine tbus_wr_engine_chk #(
  .LAYOUT (LAYOUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ack       (ack),
  .tbus      (tbus),
  .accept    (accept),
  .to_hi     (to_hi),
  .to_lo     (to_lo),
  .finish    (finish)
);

// File: tb/tbus_wr_engine_test.sv
`timescale 1ns/1ps
module tbus_wr_engine_test;

  localparam int PH   = 3;
  localparam int NVEC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_port = '0;
  logic [7:0]  req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        rdy0, rdy1, ack0, ack1;
  logic [23:0] bus0, bus1;

  int n_chk = 0;
  int n_bad = 0;

  // {port, addr, data}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 8'h06, 8'h04},
    {3'd7, 8'hFF, 8'hFF},
    {3'd5, 8'hA3, 8'h5C},
    {3'd2, 8'h1C, 8'h81},
    {3'd1, 8'h00, 8'h00},
    {3'd6, 8'hF0, 8'h0F}
  };

  always #2 clk = ~clk;

  tbus_wr_engine #(.LAYOUT(0), .PHASE_CYCLES(PH), .PORT_W(3), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_port(req_port), .req_addr(req_addr), .req_data(req_data),
    .ack(ack0), .tbus(bus0));

  tbus_wr_engine #(.LAYOUT(1), .PHASE_CYCLES(PH), .PORT_W(3), .ADDR_W(8)) uut_l1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_port(req_port), .req_addr(req_addr), .req_data(req_data),
    .ack(ack1), .tbus(bus1));

  function automatic logic [23:0] exp_w(int lay, logic [2:0] p, logic [7:0] a,
                                        logic [7:0] d, logic ck);
    if (lay == 0) return {1'b1, ck, 1'b1, 2'b00, p, a, d};
    return {8'h00, 1'b1, ck, 1'b1, p[0], a[3:0], d};
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_req(logic [2:0] p, logic [7:0] a, logic [7:0] d);
    req_port = p; req_addr = a; req_data = d; req_valid = 1'b1;
  endtask

  // call at a negedge with a request driven; returns at the ack negedge
  task automatic run_write(logic [2:0] p, logic [7:0] a, logic [7:0] d, bit poke);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3 * PH; k++) begin
      logic ck;
      ck = (k / PH == 1);
      chk("R3,R5 layout0 word", bus0, exp_w(0, p, a, d, ck));
      chk("R4,R5 layout1 word", bus1, exp_w(1, p, a, d, ck));
      chk("R6 clock phase", {23'd0, bus0[22]}, {23'd0, ck});
      chk("R7 we/rst high", {22'd0, bus1[15], bus1[13]}, 24'd3);
      chk("R8 busy ready low", {22'd0, rdy0, rdy1}, 24'd0);
      if (k == 0) chk("R2 data field", {16'd0, bus1[7:0]}, {16'd0, d});
      chk("R9 no early ack", {22'd0, ack0, ack1}, 24'd0);
      if (poke && k == 1) drive_req(~p, ~a, ~d);
      if (poke && k == 3 * PH - 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R9 ack and ready", {20'd0, ack0, ack1, rdy0, rdy1}, 24'hF);
    chk("R10 word held after write", bus0, exp_w(0, p, a, d, 1'b0));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset bus0", bus0, 24'd0);
    chk("R1 reset bus1", bus1, 24'd0);
    chk("R1 reset ready/ack", {20'd0, rdy0, rdy1, ack0, ack1}, 24'hC);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {bus0[23:4], rdy0, rdy1, ack0, ack1}, 24'hC);

    // table walk, each followed by an idle cycle
    for (int i = 0; i < NVEC; i++) begin
      drive_req(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0]);
      run_write(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
      @(negedge clk);
      chk("R9 ack one cycle", {22'd0, ack0, ack1}, 24'd0);
      repeat (2) @(negedge clk);
      chk("R10 idle hold l0", bus0, exp_w(0, VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], 1'b0));
      chk("R10 idle hold l1", bus1, exp_w(1, VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], 1'b0));
    end

    // request raised while busy must be ignored
    drive_req(3'd3, 8'h5A, 8'hC3);
    run_write(3'd3, 8'h5A, 8'hC3, 1'b1);
    @(negedge clk);
    chk("R8 busy request ignored", bus0, exp_w(0, 3'd3, 8'h5A, 8'hC3, 1'b0));
    chk("R8 still idle", {22'd0, rdy0, rdy1}, 24'd3);

    // back-to-back: new request in the ack cycle
    drive_req(3'd4, 8'h33, 8'hAA);
    run_write(3'd4, 8'h33, 8'hAA, 1'b0);
    drive_req(3'd1, 8'hE7, 8'h19);
    run_write(3'd1, 8'hE7, 8'h19, 1'b0);
    @(negedge clk);

    // reset during the high phase
    drive_req(3'd2, 8'h44, 8'h66);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (PH + 1) @(negedge clk);
    chk("R6 high before reset", {23'd0, bus0[22]}, 24'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-write reset bus", bus0 | bus1, 24'd0);
    chk("R1 mid-write reset ready", {22'd0, rdy0, rdy1}, 24'd3);
    rst_n = 1'b1;
    repeat (PH * 4) @(negedge clk);
    chk("R1 abandoned write stays off", bus0 | bus1, 24'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule